// File: doc/BRIEF.md
# SPI Master Frame Sequencer

This block is the master-side frame engine of a synchronous serial port. It takes words from a transmit queue, shifts them out most significant bit first on MOSI, and drives the serial clock and an active-low select. It shifts MISO into a receive word at the same time. The serial clock idles low. A phase input picks one of two modes. In mode 0, data is presented before the first clock edge and captured on rising edges. In mode 1, data is launched on rising edges and captured on falling edges.

A frame begins when the port is enabled and the queue holds a word. Word length is programmable between 4 and 16 bits. Each serial clock half period lasts a programmable number of system clocks. When several words are queued they follow back to back. In mode 0 the select is raised briefly between words. In mode 1 it stays low and the serial clock runs on without a pause. When the last word is done, the select is released a full serial clock period after the last capture edge. Each completed word is handed out right-aligned with a one-cycle valid strobe.

Top module: `spi_frame_master`

## Requirements
- R1: Whenever no frame is active (cs_n high), sck is 0 and mosi_oe is 0. This holds after reset and between bursts.
- R2: cs_n falls only on the cycle after one in which enable and tx_valid were both 1. mosi_oe rises together with that fall. With enable at 0, queued words are not started.
- R3: The word length is frame_bits clamped to the range 4..16. Each word has exactly that many sck rising edges. The bits on MOSI are the low bits of tx_data, most significant bit first, and tx_data bits above the length are ignored.
- R4: The first sck rising edge comes clk_div system cycles after cs_n falls. Every sck high phase and low phase inside a select lasts clk_div cycles. A clk_div of 0 acts as 1.
- R5: With cpha=0, the MSB is on MOSI from the cs_n fall. MOSI and MISO are captured on sck rising edges, and MOSI changes on falling edges.
- R6: With cpha=1, MOSI changes on sck rising edges and MISO is captured on falling edges.
- R7: cs_n rises exactly 2*clk_div cycles after the last capture edge of a word that is not followed within the same select. sck is low when cs_n rises.
- R8: With cpha=0 and another word queued while enabled, cs_n goes high for exactly 2*clk_div cycles between words.
- R9: With cpha=1 and further words queued while enabled, cs_n stays low for the whole burst. The sck low phase between words is the normal clk_div cycles.
- R10: Each completed word gives a one-cycle rx_valid pulse. rx_data then holds the received bits right-aligned, with zeros above the word length.
- R11: tx_pop is asserted for exactly one cycle per word, on the edge where that word is loaded, and only while tx_valid is 1.
- R12: Clearing enable during a word lets that word finish. No further word starts, and the outputs return to the idle levels.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| enable | input | 1 | Allows new words to start |
| cpha | input | 1 | Clock phase select (0 or 1) |
| frame_bits | input | 5 | Word length, clamped to 4..16 |
| clk_div | input | 8 | System cycles per sck half period (0 treated as 1) |
| tx_valid | input | 1 | Transmit queue holds a word |
| tx_data | input | 16 | Head word of the transmit queue |
| tx_pop | output | 1 | Consume the head word of the queue |
| miso | input | 1 | Serial data from the slave |
| sck | output | 1 | Serial clock, idles low |
| cs_n | output | 1 | Active-low slave select |
| mosi | output | 1 | Serial data to the slave |
| mosi_oe | output | 1 | Output enable for mosi (0 means high impedance) |
| rx_data | output | 16 | Received word, right-aligned |
| rx_valid | output | 1 | One-cycle strobe for rx_data |

## Verification
The bench sweeps both phases over every frame_bits value from 3 to 17 and over clk_div values 0, 1 and 3. Each point runs a three-word burst against a slave model that launches and captures on the edges of the selected mode. This exposes a design that counts one half period too few or too many at the frame boundaries: its select release or inter-word gap would be off by clk_div cycles, or its bit count would differ from the clamped length. It also exposes a design that pulses the select in mode 1, or keeps it low in mode 0, through the count of select falls per burst. A swapped launch or capture edge would corrupt the received words. Further cases clear enable in the middle of a word, where a faulty design would either cut the word short or start the next queued word. Other cases hold words in the queue while disabled, where a faulty design would start a frame.

// File: rtl/spi_seq_pkg.sv
// Shared types for the SPI frame sequencer.
// Assumes: used by spi_frame_master and its submodules only.
package spi_seq_pkg;

    // Sequencer states: idle, lead-in half period, shifting, release wait, select gap
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_LEAD  = 3'd1,
        ST_SHIFT = 3'd2,
        ST_TRAIL = 3'd3,
        ST_GAP   = 3'd4
    } seq_state_t;

endpackage

// File: rtl/spi_half_timer.sv
// Half-period timer: while run is high, pulses tick once every div system cycles.
// A div of 0 acts as 1. The count restarts at zero whenever run is low.
// Assumes: div is stable while run is high.
module spi_half_timer #(
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run,
    input  logic [DIV_W-1:0] div,
    output logic             tick
);

    logic [DIV_W-1:0] cnt_q;
    logic [DIV_W-1:0] limit;

    // Last count value of one half period
    always_comb begin
        if (div == '0) limit = '0;
        else           limit = div - DIV_W'(1);
    end

    assign tick = run && (cnt_q == limit);

    // Count system cycles inside the current half period
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (!run || tick) cnt_q <= '0;
        else                   cnt_q <= cnt_q + DIV_W'(1);
    end

endmodule

// File: rtl/spi_shift_unit.sv
// Transmit and receive shift registers of the frame sequencer.
// On load, the low nbits of load_word are moved to the top of the transmit
// register so that its MSB is the first bit out, and the receive register is cleared.
// Assumes: nbits is in 1..W; load and sample are never high together.
module spi_shift_unit #(
    parameter int W     = 16,
    parameter int LEN_W = 5
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [W-1:0]     load_word,
    input  logic [LEN_W-1:0] nbits,
    input  logic             shift_out,
    input  logic             sample,
    input  logic             miso,
    output logic             tx_bit,
    output logic [W-1:0]     rx_word
);

    logic [W-1:0] tx_q;
    logic [W-1:0] rx_q;

    // Transmit register: align the word on load, move it left on each launch
    always_ff @(posedge clk) begin
        if (!rst_n)         tx_q <= '0;
        else if (load)      tx_q <= load_word << (W - int'(nbits));
        else if (shift_out) tx_q <= {tx_q[W-2:0], 1'b0};
    end

    // Receive register: clear on load, shift MISO in at the LSB on each capture
    always_ff @(posedge clk) begin
        if (!rst_n)      rx_q <= '0;
        else if (load)   rx_q <= '0;
        else if (sample) rx_q <= {rx_q[W-2:0], miso};
    end

    assign tx_bit  = tx_q[W-1];
    assign rx_word = rx_q;

endmodule

// File: rtl/spi_frame_master.sv
// SPI master frame sequencer, clock idle low, with a selectable clock phase.
// A frame is a lead-in half period, 2*N clock half periods and then either a
// release wait (phase 1), a select gap (phase 0, more words), or idle.
// Configuration is latched whenever a word is loaded.
// Assumes: the transmit queue presents its head word on tx_data while tx_valid is high,
// and advances by one entry on each cycle that tx_pop is high.
module spi_frame_master #(
    parameter int MAX_BITS = 16,
    parameter int MIN_BITS = 4,
    parameter int DIV_W    = 8,
    localparam int LEN_W   = $clog2(MAX_BITS + 1),
    localparam int HALF_W  = $clog2(2 * MAX_BITS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                enable,
    input  logic                cpha,
    input  logic [LEN_W-1:0]    frame_bits,
    input  logic [DIV_W-1:0]    clk_div,
    input  logic                tx_valid,
    input  logic [MAX_BITS-1:0] tx_data,
    output logic                tx_pop,
    input  logic                miso,
    output logic                sck,
    output logic                cs_n,
    output logic                mosi,
    output logic                mosi_oe,
    output logic [MAX_BITS-1:0] rx_data,
    output logic                rx_valid
);
    import spi_seq_pkg::*;

    localparam logic [HALF_W:0] ONE_H = (HALF_W + 1)'(1);

    seq_state_t          state_q, state_d;
    logic [HALF_W-1:0]   half_q, half_d, half_inc;
    logic [HALF_W:0]     last_half;
    logic                cpha_q;
    logic [LEN_W-1:0]    nbits_q, nbits_in;
    logic [DIV_W-1:0]    div_q;
    logic                tick, more, at_last;
    logic                load, word_done, do_shift, do_sample;
    logic                tx_bit;
    logic [MAX_BITS-1:0] rx_word;

    // Clamp the requested word length into the supported range
    always_comb begin
        if (frame_bits < LEN_W'(MIN_BITS))      nbits_in = LEN_W'(MIN_BITS);
        else if (frame_bits > LEN_W'(MAX_BITS)) nbits_in = LEN_W'(MAX_BITS);
        else                                    nbits_in = frame_bits;
    end

    assign more      = enable && tx_valid;
    assign last_half = (HALF_W + 1)'({nbits_q, 1'b0}) - ONE_H;
    assign at_last   = ({1'b0, half_q} == last_half);
    assign half_inc  = half_q + HALF_W'(1);

    spi_half_timer #(.DIV_W(DIV_W)) u_timer (
        .clk   (clk),
        .rst_n (rst_n),
        .run   (state_q != ST_IDLE),
        .div   (div_q),
        .tick  (tick)
    );

    spi_shift_unit #(.W(MAX_BITS), .LEN_W(LEN_W)) u_shift (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (load),
        .load_word (tx_data),
        .nbits     (nbits_in),
        .shift_out (do_shift),
        .sample    (do_sample),
        .miso      (miso),
        .tx_bit    (tx_bit),
        .rx_word   (rx_word)
    );

    // Next-state, half-period index and shift/sample event decode
    always_comb begin
        state_d   = state_q;
        half_d    = half_q;
        load      = 1'b0;
        word_done = 1'b0;
        do_shift  = 1'b0;
        do_sample = 1'b0;
        case (state_q)
            ST_IDLE: begin
                if (more) begin
                    load    = 1'b1;
                    state_d = ST_LEAD;
                end
            end
            ST_LEAD: begin
                if (tick) begin
                    state_d   = ST_SHIFT;
                    half_d    = '0;
                    do_sample = !cpha_q;
                end
            end
            ST_SHIFT: begin
                if (tick) begin
                    if (at_last) begin
                        word_done = 1'b1;
                        half_d    = '0;
                        if (cpha_q) begin
                            if (more) load = 1'b1;
                            else      state_d = ST_TRAIL;
                        end else begin
                            state_d = more ? ST_GAP : ST_IDLE;
                        end
                    end else begin
                        half_d = half_inc;
                        if (half_inc[0]) begin
                            do_shift  = !cpha_q;
                            do_sample = cpha_q;
                        end else begin
                            do_shift  = cpha_q;
                            do_sample = !cpha_q;
                        end
                    end
                end
            end
            ST_TRAIL: begin
                if (tick) state_d = ST_IDLE;
            end
            ST_GAP: begin
                if (tick) begin
                    if (half_q == '0) begin
                        half_d = HALF_W'(1);
                    end else begin
                        half_d = '0;
                        if (more) begin
                            load    = 1'b1;
                            state_d = ST_LEAD;
                        end else begin
                            state_d = ST_IDLE;
                        end
                    end
                end
            end
            default: state_d = ST_IDLE;
        endcase
    end

    // Sequencer state and half-period index
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            half_q  <= '0;
        end else begin
            state_q <= state_d;
            half_q  <= half_d;
        end
    end

    // Latch the configuration whenever a word is loaded
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cpha_q  <= 1'b0;
            nbits_q <= LEN_W'(MIN_BITS);
            div_q   <= DIV_W'(1);
        end else if (load) begin
            cpha_q  <= cpha;
            nbits_q <= nbits_in;
            div_q   <= clk_div;
        end
    end

    // Hand out each completed receive word with a one-cycle strobe
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rx_data  <= '0;
            rx_valid <= 1'b0;
        end else begin
            rx_valid <= word_done;
            if (word_done) rx_data <= rx_word;
        end
    end

    assign tx_pop  = load;
    assign cs_n    = !((state_q == ST_LEAD) || (state_q == ST_SHIFT) || (state_q == ST_TRAIL));
    assign sck     = (state_q == ST_SHIFT) && !half_q[0];
    assign mosi_oe = !cs_n;
    assign mosi    = mosi_oe ? tx_bit : 1'b0;

endmodule

// File: rtl/spi_frame_master_checker.sv
// Protocol checker for spi_frame_master, attached to every instance with bind.
// Assumes: synchronous active-low reset; only observes the block's ports.
module spi_frame_master_checker (
    input logic clk,
    input logic rst_n,
    input logic enable,
    input logic tx_valid,
    input logic tx_pop,
    input logic sck,
    input logic cs_n,
    input logic mosi_oe,
    input logic rx_valid
);

    // R1: no serial clock outside a select
    assert_idle_sck_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !sck);

    // R1: MOSI driver off outside a select
    assert_idle_hiz_R1: assert property (@(posedge clk) disable iff (!rst_n)
        cs_n |-> !mosi_oe);

    // R2: a select only opens after enable and queued data
    assert_start_gated_R2: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(enable && tx_valid));

    // R11: opening a select consumes one queue entry
    assert_start_pops_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(cs_n) |-> $past(tx_pop));

    // R11: never pop an empty queue
    assert_pop_valid_R11: assert property (@(posedge clk) disable iff (!rst_n)
        tx_pop |-> tx_valid);

    // R10: receive strobe lasts one cycle
    assert_rx_single_R10: assert property (@(posedge clk) disable iff (!rst_n)
        rx_valid |=> !rx_valid);

    // R7: select is released with the serial clock low
    assert_release_sck_low_R7: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(cs_n) |-> !$past(sck));

endmodule

bind spi_frame_master spi_frame_master_checker u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .enable   (enable),
    .tx_valid (tx_valid),
    .tx_pop   (tx_pop),
    .sck      (sck),
    .cs_n     (cs_n),
    .mosi_oe  (mosi_oe),
    .rx_valid (rx_valid)
);

// File: tb/spi_frame_master_test.sv
// Sweep bench: both phases, every word length 3..17, dividers 0/1/3,
// plus start gating and enable-clear cases, against a bench slave model.
module spi_frame_master_test;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        enable;
    logic        cpha;
    logic [4:0]  frame_bits;
    logic [7:0]  clk_div;
    logic        tx_valid;
    logic [15:0] tx_data;
    logic        tx_pop;
    logic        miso_b = 1'b0;
    logic        sck, cs_n, mosi, mosi_oe, rx_valid;
    logic [15:0] rx_data;

    int checks = 0, errors = 0;
    int qidx = 0, qcnt = 0;
    int cpha_b = 0, nb = 8, hb = 1;
    bit finished = 0;

    // monitor/slave state
    int cyc = 0, t_fall_cs = 0, t_rise_cs = 0, t_cap = 0, t_rise = 0, t_fall = 0;
    int n_csfall = 0, n_rise = 0, win = 0, rv = 0, ws_out = 0, incnt = 0, outcnt = 0;
    bit first_rise = 0, gap_pending = 0;
    logic prev_sck = 0, prev_cs = 1, prev_rxv = 0;
    logic [15:0] s_sh = '0;

    always #5 clk = ~clk;

    function automatic logic [15:0] txw(input int i);
        return 16'((i * 37957 + 4660) ^ (i * i * 11));
    endfunction

    function automatic logic [15:0] sww(input int i);
        return 16'((i * 52711 + 43981) ^ (i << 5));
    endfunction

    function automatic logic [15:0] msk(input int n);
        return 16'((32'd1 << n) - 1);
    endfunction

    assign tx_valid = (qidx < qcnt);
    assign tx_data  = txw(qidx);

    spi_frame_master uut (
        .clk(clk), .rst_n(rst_n), .enable(enable), .cpha(cpha),
        .frame_bits(frame_bits), .clk_div(clk_div), .tx_valid(tx_valid),
        .tx_data(tx_data), .tx_pop(tx_pop), .miso(miso_b), .sck(sck),
        .cs_n(cs_n), .mosi(mosi), .mosi_oe(mosi_oe), .rx_data(rx_data),
        .rx_valid(rx_valid)
    );

    // Queue model: advance the head on each pop
    always @(posedge clk) begin
        if (rst_n && tx_pop) qidx <= qidx + 1;
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Slave model and timing monitor, sampled away from the active edge
    always @(negedge clk) begin
        if (!rst_n) begin
            prev_sck <= 1'b0;
            prev_cs  <= 1'b1;
            prev_rxv <= 1'b0;
        end else begin
            cyc++;
            if (prev_cs && !cs_n) begin
                n_csfall++;
                t_fall_cs = cyc;
                first_rise = 1;
                chk(mosi_oe == 1'b1, "R2 mosi_oe at select", mosi_oe, 1);
                if (gap_pending) chk(cyc - t_rise_cs == 2 * hb, "R8 select gap", cyc - t_rise_cs, 2 * hb);
                gap_pending = 0;
                if (cpha_b == 0) begin
                    outcnt = 0;
                    miso_b = sww(ws_out)[nb - 1];
                end
            end
            if (!prev_cs && cs_n) begin
                t_rise_cs = cyc;
                chk(cyc - t_cap == 2 * hb, "R7 select release", cyc - t_cap, 2 * hb);
                chk(incnt == 0, "R3 whole words per select", incnt, 0);
                gap_pending = (cpha_b == 0) && (qidx < qcnt) && enable;
            end
            if (!prev_sck && sck) begin
                n_rise++;
                chk(!cs_n, "R9 sck inside select", cs_n, 0);
                if (first_rise) chk(cyc - t_fall_cs == hb, "R4 lead-in", cyc - t_fall_cs, hb);
                else            chk(cyc - t_fall == hb, "R4 low phase", cyc - t_fall, hb);
                first_rise = 0;
                t_rise = cyc;
            end
            if (prev_sck && !sck) begin
                chk(cyc - t_rise == hb, "R4 high phase", cyc - t_rise, hb);
                t_fall = cyc;
            end
            // capture edge of the selected mode
            if ((cpha_b == 0 && !prev_sck && sck) || (cpha_b == 1 && prev_sck && !sck)) begin
                t_cap = cyc;
                s_sh = {s_sh[14:0], mosi};
                incnt++;
                if (incnt == nb) begin
                    chk((s_sh & msk(nb)) == (txw(win) & msk(nb)), cpha_b ? "R6 mosi word" : "R5 mosi word",
                        s_sh & msk(nb), txw(win) & msk(nb));
                    win++;
                    incnt = 0;
                end
            end
            // launch edges of the slave
            if (cpha_b == 0 && prev_sck && !sck) begin
                outcnt++;
                if (outcnt == nb) begin outcnt = 0; ws_out++; end
                else miso_b = sww(ws_out)[nb - 1 - outcnt];
            end
            if (cpha_b == 1 && !prev_sck && sck) begin
                miso_b = sww(ws_out)[nb - 1 - outcnt];
                outcnt++;
                if (outcnt == nb) begin outcnt = 0; ws_out++; end
            end
            if (rx_valid) begin
                chk(!prev_rxv, "R10 single strobe", prev_rxv, 0);
                chk(rx_data == (sww(rv) & msk(nb)), cpha_b ? "R6 rx word" : "R5 rx word",
                    rx_data, sww(rv) & msk(nb));
                chk((rx_data & ~msk(nb)) == 0, "R10 upper bits zero", rx_data & ~msk(nb), 0);
                rv++;
            end
            prev_sck <= sck;
            prev_cs  <= cs_n;
            prev_rxv <= rx_valid;
        end
    end

    task automatic set_cfg(input int c, input int fb, input int d);
        cpha_b = c;
        nb = (fb < 4) ? 4 : ((fb > 16) ? 16 : fb);
        hb = (d == 0) ? 1 : d;
        cpha = c[0];
        frame_bits = 5'(fb);
        clk_div = 8'(d);
    endtask

    task automatic idle_check(input string tag);
        chk(cs_n == 1'b1, tag, cs_n, 1);
        chk(sck == 1'b0, tag, sck, 0);
        chk(mosi_oe == 1'b0, tag, mosi_oe, 0);
    endtask

    task automatic wait_done(input int target);
        int t = 0;
        while (!(win >= target && rv >= target && cs_n && qidx == qcnt) && t < 20000) begin
            @(negedge clk);
            t++;
        end
        chk(t < 20000, "R11 burst drained", t, 0);
        repeat (3) @(negedge clk);
    endtask

    task automatic run_burst(input int c, input int fb, input int d, input int nw);
        int f0, r0, w0, v0, p0;
        @(negedge clk);
        set_cfg(c, fb, d);
        f0 = n_csfall; r0 = n_rise; w0 = win; v0 = rv; p0 = qidx;
        qcnt += nw;
        enable = 1'b1;
        wait_done(w0 + nw);
        chk(n_rise - r0 == nw * nb, "R3 clock edges per burst", n_rise - r0, nw * nb);
        chk(rv - v0 == nw, "R10 strobes per burst", rv - v0, nw);
        chk(qidx - p0 == nw, "R11 pops per burst", qidx - p0, nw);
        if (c == 1) chk(n_csfall - f0 == 1, "R9 one select per burst", n_csfall - f0, 1);
        else        chk(n_csfall - f0 == nw, "R8 select per word", n_csfall - f0, nw);
        idle_check("R1 idle after burst");
    endtask

    task automatic enable_drop(input int c);
        int w0, v0, p0;
        @(negedge clk);
        set_cfg(c, 8, 2);
        w0 = win; v0 = rv; p0 = qidx;
        qcnt += 3;
        enable = 1'b1;
        while (cs_n) @(negedge clk);
        repeat (3) @(negedge clk);
        enable = 1'b0;
        while (!(win >= w0 + 1 && rv >= v0 + 1 && cs_n)) @(negedge clk);
        repeat (30) @(negedge clk);
        chk(win == w0 + 1, "R12 current word finished", win - w0, 1);
        chk(rv == v0 + 1, "R12 one strobe", rv - v0, 1);
        chk(qidx == p0 + 1, "R12 no further pop", qidx - p0, 1);
        idle_check("R12 idle after enable clear");
        enable = 1'b1;
        wait_done(w0 + 3);
    endtask

    // Watchdog: a hung run counts as a failure
    initial begin
        repeat (195000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual %0d expected %0d", 195000, 0);
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        int dv[3] = '{0, 1, 3};
        rst_n = 1'b0;
        enable = 1'b0;
        set_cfg(0, 8, 1);
        repeat (4) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        @(negedge clk);
        idle_check("R1 reset state");
        chk(rx_valid == 1'b0, "R10 reset strobe", rx_valid, 0);
        chk(tx_pop == 1'b0, "R11 reset pop", tx_pop, 0);

        // R2: queued words wait for enable
        set_cfg(0, 8, 2);
        qcnt += 2;
        repeat (40) @(negedge clk);
        chk(cs_n == 1'b1, "R2 no start while disabled", cs_n, 1);
        chk(qidx == 0, "R2 no pop while disabled", qidx, 0);
        enable = 1'b1;
        wait_done(2);

        for (int c = 0; c < 2; c++)
            for (int fb = 3; fb <= 17; fb++)
                for (int k = 0; k < 3; k++)
                    run_burst(c, fb, dv[k], 3);

        enable_drop(0);
        enable_drop(1);

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule